// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the programming front end of an eight-line interrupt controller. A host reaches it through a byte-wide port with one address bit. Writes with the address bit low are decoded by their data bits into a start-of-initialization word, a mode word (read select, poll, special mask) or a priority/end-of-interrupt command. Writes with the address bit high go either to the next expected initialization word or, in normal operation, to the interrupt mask register.

The block keeps the mask, the in-service register, the vector base, the rotating priority offset and the mode flags. The request register lives outside the block: the block reads it on `irr_in` and, when requests must be forgotten, reports the lines to clear on the one-cycle pulse `irr_clr`. A shared priority resolver ranks the lines by rotating priority. It drives the interrupt output, non-specific end-of-interrupt and the poll acknowledge.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset the unit is in normal mode, the mask, in-service register, priority offset, vector base and all mode flags are zero, and `irr_clr` is zero.
- R2: A write with `addr`=0 and `wdata[4]`=1 starts initialization. It clears the mask, the in-service register, the priority offset, poll, read select, special mask and rotate-on-auto-EOI. In the next cycle `irr_clr` is the inverse of `lvl_mask` for one cycle.
- R3: If `wdata[0]` of the start word is 0, auto-EOI and special fully nested mode are cleared. If it is 1, both keep their values.
- R4: The next `addr`=1 write sets the vector base to `wdata & 8'hF8`. A third word is expected only when `wdata[1]` of the start word was 0, and a fourth only when its `wdata[0]` was 1. After the last expected word, `addr`=1 writes load the mask.
- R5: The fourth word sets special fully nested mode (`sfn_mode`) from `wdata[4]` and auto-EOI from `wdata[1]`.
- R6: `int_out` is low from the cycle after a start word until the last expected initialization word has been written.
- R7: An `addr`=0 write with `wdata[4]`=0 and `wdata[3]`=1 is a mode word. `wdata[2]` arms poll. `wdata[1]`=1 sets read select to `wdata[0]`. `wdata[6]`=1 sets special mask mode to `wdata[5]`. A normal read returns the value in `rdata` the cycle after `rd_en`: `irr_in` (read select 0) or the in-service register (read select 1) for `addr`=0, and the mask for `addr`=1.
- R8: An `addr`=0 write with `wdata[4:3]`=0 is a command with code `wdata[7:5]`. Code 4 sets and code 0 clears rotate-on-auto-EOI. Code 2 changes nothing.
- R9: Line priority rank is (line − offset) mod 8, and a smaller rank wins. Codes 1 and 5 clear the best-ranked in-service bit, skipping masked lines in special mask mode, and do nothing when no such bit is set.
- R10: Codes 3 and 7 clear in-service bit `wdata[2:0]`. Codes 5 and 7 set the offset to (cleared line + 1) mod 8. Code 6 sets the offset to (`wdata[2:0]` + 1) mod 8.
- R11: Outside initialization, `int_out` is high exactly when an unmasked request ranks strictly better than the best in-service line. In special mask mode, masked in-service lines are excluded.
- R12: A read while poll is armed disarms poll. If `int_out` was high, `rdata` = `{1'b1, 4'b0, line}` of the winning request, `irr_clr` pulses that line unless it is level-triggered, and its in-service bit is set, or, in auto-EOI with rotation on, the offset becomes line + 1. Otherwise `rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one operation per cycle |
| rd_en | input | 1 | Read strobe, ignored when `wr_en` is high |
| addr | input | 1 | Port address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irr_in | input | 8 | Current request register |
| lvl_mask | input | 8 | Level-triggered lines (1 = level) |
| irr_clr | output | 8 | One-cycle pulse of request bits to clear |
| int_out | output | 1 | Interrupt output |
| vec_base | output | 8 | Programmed vector base |
| sfn_mode | output | 1 | Special fully nested mode flag |

## Verification
The assertions check, on every cycle, the effects that follow from one strobe: a start word leaves the mask and in-service register empty and pulses the inverted level mask, the output goes quiet during initialization, mask writes in normal mode land, a poll read disarms poll, a specific end-of-interrupt removes its bit, and the in-service register and mask stay still when the port is idle. Rotating priority can only be shown by the bench's scenarios, since it is visible only as the order of end-of-interrupt and poll results. The same holds for the skipping of the third and fourth initialization words, for special mask mode, and for auto-EOI rotation.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

    localparam int DW    = 8;
    localparam int LINES = 8;
    localparam int LW    = $clog2(LINES);

    // Bit positions inside control words
    localparam int B_START  = 4;
    localparam int B_MODEW  = 3;
    localparam int B_POLL   = 2;
    localparam int B_RSEL_E = 1;
    localparam int B_RSEL_V = 0;
    localparam int B_SMM_E  = 6;
    localparam int B_SMM_V  = 5;
    localparam int B_NEED4  = 0;
    localparam int B_SINGLE = 1;
    localparam int B_SFN    = 4;
    localparam int B_AEOI   = 1;

    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_W2  = 2'd1,
        ST_W3  = 2'd2,
        ST_W4  = 2'd3
    } init_st_e;

    typedef enum logic [2:0] {
        CMD_ROT_CLR = 3'd0,
        CMD_NS_EOI  = 3'd1,
        CMD_NOP     = 3'd2,
        CMD_SP_EOI  = 3'd3,
        CMD_ROT_SET = 3'd4,
        CMD_NS_ROT  = 3'd5,
        CMD_SET_PRI = 3'd6,
        CMD_SP_ROT  = 3'd7
    } cmd_e;

    typedef struct packed {
        logic start;
        logic modew;
        logic cmdw;
        logic dataw;
    } wr_kind_t;

    typedef struct packed {
        logic aeoi;
        logic rot_aeoi;
        logic smm;
        logic sfn;
        logic poll;
        logic rsel;
    } mode_t;

    function automatic wr_kind_t classify(input logic en, input logic a0,
                                          input logic [DW-1:0] d);
        wr_kind_t k;
        k.start = en && !a0 && d[B_START];
        k.modew = en && !a0 && !d[B_START] && d[B_MODEW];
        k.cmdw  = en && !a0 && !d[B_START] && !d[B_MODEW];
        k.dataw = en && a0;
        return k;
    endfunction

endpackage

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    input  logic [LW-1:0] offset,
    output logic          hit,
    output logic [LW-1:0] line,
    output logic [LW:0]   rank
);
    logic [N-1:0] rot;

    // rot[k] is the line whose rank is k
    for (genvar k = 0; k < N; k++) begin : g_rot
        logic [LW-1:0] src;
        assign src    = offset + LW'(k);
        assign rot[k] = mask[src];
    end

    always_comb begin
        hit  = 1'b0;
        line = '0;
        rank = (LW+1)'(N);
        for (int k = N - 1; k >= 0; k--) begin
            if (rot[k]) begin
                hit  = 1'b1;
                line = offset + LW'(k);
                rank = (LW+1)'(k);
            end
        end
    end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     single_in,
    input  logic     need4_in,
    input  logic     data_wr,
    output init_st_e stage,
    output logic     busy
);
    init_st_e st_q;
    logic     single_q;
    logic     need4_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_RUN;
            single_q <= 1'b0;
            need4_q  <= 1'b0;
        end else if (start) begin
            st_q     <= ST_W2;
            single_q <= single_in;
            need4_q  <= need4_in;
        end else if (data_wr) begin
            unique case (st_q)
                ST_W2:   st_q <= !single_q ? ST_W3 : (need4_q ? ST_W4 : ST_RUN);
                ST_W3:   st_q <= need4_q ? ST_W4 : ST_RUN;
                ST_W4:   st_q <= ST_RUN;
                default: st_q <= ST_RUN;
            endcase
        end
    end

    assign stage = st_q;
    assign busy  = (st_q != ST_RUN);
endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
    import pic_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] irr_in,
    input  logic [DW-1:0] lvl_mask,
    output logic [DW-1:0] irr_clr,
    output logic          int_out,
    output logic [DW-1:0] vec_base,
    output logic          sfn_mode
);
    logic [LINES-1:0] imr;
    logic [LINES-1:0] isr;
    logic [LW-1:0]    offset;
    logic [DW-1:0]    vec_q;
    mode_t            mode_q;
    logic [DW-1:0]    rdata_q;
    logic [DW-1:0]    clr_q;

    wr_kind_t  kind;
    init_st_e  stage;
    logic      busy;
    cmd_e      cmd;
    logic [LW-1:0] sel_line;

    assign kind     = classify(wr_en, addr, wdata);
    assign cmd      = cmd_e'(wdata[DW-1:DW-3]);
    assign sel_line = wdata[LW-1:0];

    pic_init_seq u_init (
        .clk       (clk),
        .rst       (rst),
        .start     (kind.start),
        .single_in (wdata[B_SINGLE]),
        .need4_in  (wdata[B_NEED4]),
        .data_wr   (kind.dataw),
        .stage     (stage),
        .busy      (busy)
    );

    // Request side of the resolver
    logic [LINES-1:0] req_vec;
    logic             rq_hit;
    logic [LW-1:0]    rq_line;
    logic [LW:0]      rq_rank;

    assign req_vec = irr_in[LINES-1:0] & ~imr;

    pic_prio_pick #(.N(LINES)) u_req_pick (
        .mask   (req_vec),
        .offset (offset),
        .hit    (rq_hit),
        .line   (rq_line),
        .rank   (rq_rank)
    );

    // In-service side: blocks lower requests and picks the non-specific EOI line
    logic [LINES-1:0] svc_vec;
    logic             sv_hit;
    logic [LW-1:0]    sv_line;
    logic [LW:0]      sv_rank;

    assign svc_vec = mode_q.smm ? (isr & ~imr) : isr;

    pic_prio_pick #(.N(LINES)) u_svc_pick (
        .mask   (svc_vec),
        .offset (offset),
        .hit    (sv_hit),
        .line   (sv_line),
        .rank   (sv_rank)
    );

    logic grant;
    logic poll_rd;
    assign grant   = rq_hit && (rq_rank < sv_rank);
    assign int_out = grant && !busy;
    assign poll_rd = rd_en && !wr_en && mode_q.poll;

    always_ff @(posedge clk) begin
        if (rst) begin
            imr     <= '0;
            isr     <= '0;
            offset  <= '0;
            vec_q   <= '0;
            mode_q  <= '0;
            rdata_q <= '0;
            clr_q   <= '0;
        end else begin
            clr_q <= '0;
            if (kind.start) begin
                clr_q           <= ~lvl_mask;
                imr             <= '0;
                isr             <= '0;
                offset          <= '0;
                mode_q.rot_aeoi <= 1'b0;
                mode_q.smm      <= 1'b0;
                mode_q.rsel     <= 1'b0;
                mode_q.poll     <= 1'b0;
                if (!wdata[B_NEED4]) begin
                    mode_q.aeoi <= 1'b0;
                    mode_q.sfn  <= 1'b0;
                end
            end else if (kind.modew) begin
                if (wdata[B_POLL])   mode_q.poll <= 1'b1;
                if (wdata[B_RSEL_E]) mode_q.rsel <= wdata[B_RSEL_V];
                if (wdata[B_SMM_E])  mode_q.smm  <= wdata[B_SMM_V];
            end else if (kind.cmdw) begin
                unique case (cmd)
                    CMD_ROT_CLR, CMD_ROT_SET:
                        mode_q.rot_aeoi <= cmd[2];
                    CMD_NS_EOI, CMD_NS_ROT: begin
                        if (sv_hit) begin
                            isr[sv_line] <= 1'b0;
                            if (cmd[2]) offset <= sv_line + LW'(1);
                        end
                    end
                    CMD_SP_EOI, CMD_SP_ROT: begin
                        isr[sel_line] <= 1'b0;
                        if (cmd[2]) offset <= sel_line + LW'(1);
                    end
                    CMD_SET_PRI:
                        offset <= sel_line + LW'(1);
                    default: ;
                endcase
            end else if (kind.dataw) begin
                unique case (stage)
                    ST_RUN: imr   <= wdata[LINES-1:0];
                    ST_W2:  vec_q <= {wdata[DW-1:LW], {LW{1'b0}}};
                    ST_W4: begin
                        mode_q.sfn  <= wdata[B_SFN];
                        mode_q.aeoi <= wdata[B_AEOI];
                    end
                    default: ;
                endcase
            end else if (poll_rd) begin
                mode_q.poll <= 1'b0;
                if (int_out) begin
                    rdata_q          <= {1'b1, {(DW-1-LW){1'b0}}, rq_line};
                    clr_q[rq_line]   <= !lvl_mask[rq_line];
                    if (!mode_q.aeoi)
                        isr[rq_line] <= 1'b1;
                    else if (mode_q.rot_aeoi)
                        offset <= rq_line + LW'(1);
                end else begin
                    rdata_q <= '0;
                end
            end else if (rd_en) begin
                if (addr)
                    rdata_q <= imr;
                else
                    rdata_q <= mode_q.rsel ? isr : irr_in;
            end
        end
    end

    assign rdata    = rdata_q;
    assign irr_clr  = clr_q;
    assign vec_base = vec_q;
    assign sfn_mode = mode_q.sfn;
endmodule

// File: rtl/pic_cmd_seq_chk.sv
module pic_cmd_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic       addr,
    input logic [7:0] wdata,
    input logic [7:0] lvl_mask,
    input logic [7:0] irr_clr,
    input logic       int_out,
    input logic [7:0] imr,
    input logic [7:0] isr,
    input logic       busy,
    input logic       poll_pend
);
    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[4]) |=>
            (imr == 8'h00 && isr == 8'h00 && !poll_pend && irr_clr == ~$past(lvl_mask)));

    // R6
    init_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[4]) |=> !int_out);

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr && !busy) |=> (imr == $past(wdata)));

    // R12
    poll_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && poll_pend) |=> !poll_pend);

    // R10
    spec_eoi_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[7:3] == 5'b01100) |=> !isr[$past(wdata[2:0])]);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !rd_en) |=> ($stable(isr) && $stable(imr)));

    // R12
    clr_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (irr_clr != 8'h00) |-> $past(wr_en || rd_en));
endmodule

bind pic_cmd_seq pic_cmd_seq_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .lvl_mask  (lvl_mask),
    .irr_clr   (irr_clr),
    .int_out   (int_out),
    .imr       (imr),
    .isr       (isr),
    .busy      (busy),
    .poll_pend (mode_q.poll)
);

// File: tb/pic_cmd_seq_tb.sv
module pic_cmd_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] irr_in = 8'h00;
    logic [7:0] lvl_mask = 8'h00;
    logic [7:0] irr_clr;
    logic       int_out;
    logic [7:0] vec_base;
    logic       sfn_mode;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pic_cmd_seq dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irr_in(irr_in), .lvl_mask(lvl_mask),
        .irr_clr(irr_clr), .int_out(int_out), .vec_base(vec_base),
        .sfn_mode(sfn_mode)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic poll(output logic [7:0] v);
        wr(1'b0, 8'h0C);
        rd(1'b0, v);
    endtask

    task automatic init_single();
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h08);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 irr_clr", irr_clr, 8'h00);
        chk("R1 vec_base", vec_base, 8'h00);
        chk("R1 sfn_mode", {7'b0, sfn_mode}, 8'h00);
        irr_in = 8'h5A; #1;
        chk("R1 R11 int_out", {7'b0, int_out}, 8'h01);
        rd(1'b1, v); chk("R1 mask", v, 8'h00);
        rd(1'b0, v); chk("R1 R7 irr read", v, 8'h5A);
    endtask

    task automatic t_init_full();
        logic [7:0] v;
        lvl_mask = 8'h0C; irr_in = 8'hFF;
        wr(1'b0, 8'h11);
        chk("R2 irr_clr", irr_clr, 8'hF3);
        chk("R6 after start", {7'b0, int_out}, 8'h00);
        wr(1'b1, 8'h47);
        chk("R4 vec_base", vec_base, 8'h40);
        wr(1'b1, 8'h04);
        chk("R6 after word3", {7'b0, int_out}, 8'h00);
        wr(1'b1, 8'h12);
        chk("R5 sfn set", {7'b0, sfn_mode}, 8'h01);
        chk("R6 R11 done", {7'b0, int_out}, 8'h01);
        wr(1'b1, 8'hF0);
        rd(1'b1, v); chk("R4 mask write", v, 8'hF0);
        chk("R11 unmasked low lines", {7'b0, int_out}, 8'h01);
        lvl_mask = 8'h00; irr_in = 8'h00;
    endtask

    task automatic t_init_skip3();
        logic [7:0] v;
        wr(1'b0, 8'h13);
        chk("R3 keep sfn", {7'b0, sfn_mode}, 8'h01);
        rd(1'b1, v); chk("R2 mask cleared", v, 8'h00);
        wr(1'b1, 8'h20);
        chk("R4 vec_base", vec_base, 8'h20);
        wr(1'b1, 8'h10);
        chk("R5 word4 sfn", {7'b0, sfn_mode}, 8'h01);
        rd(1'b1, v); chk("R4 word4 not mask", v, 8'h00);
    endtask

    task automatic t_init_single();
        logic [7:0] v;
        wr(1'b0, 8'h12);
        chk("R3 clear sfn", {7'b0, sfn_mode}, 8'h00);
        wr(1'b1, 8'h88);
        chk("R4 vec_base", vec_base, 8'h88);
        wr(1'b1, 8'h55);
        rd(1'b1, v); chk("R4 mask after single", v, 8'h55);
        chk("R4 vec kept", vec_base, 8'h88);
    endtask

    task automatic t_mode_read();
        logic [7:0] v;
        init_single();
        irr_in = 8'h05;
        wr(1'b0, 8'h0B);
        rd(1'b0, v); chk("R7 isr read", v, 8'h00);
        poll(v); chk("R12 poll value", v, 8'h80);
        chk("R12 irr_clr", irr_clr, 8'h01);
        irr_in = 8'h04; #1;
        rd(1'b0, v); chk("R12 R7 isr after poll", v, 8'h01);
        chk("R11 blocked", {7'b0, int_out}, 8'h00);
        wr(1'b0, 8'h0A);
        rd(1'b0, v); chk("R7 irr read", v, 8'h04);
        wr(1'b0, 8'h09);
        rd(1'b0, v); chk("R7 rsel unchanged", v, 8'h04);
        rd(1'b1, v); chk("R7 mask read", v, 8'h00);
        poll(v); chk("R12 empty poll", v, 8'h00);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); chk("R12 isr unchanged", v, 8'h01);
    endtask

    task automatic t_eoi();
        logic [7:0] v;
        init_single();
        wr(1'b0, 8'h0B);
        irr_in = 8'h80; poll(v); chk("R12 line7", v, 8'h87);
        irr_in = 8'h10; poll(v); chk("R11 R12 line4", v, 8'h84);
        irr_in = 8'h02; poll(v); chk("R12 line1", v, 8'h81);
        irr_in = 8'h00;
        rd(1'b0, v); chk("R12 isr", v, 8'h92);
        wr(1'b0, 8'h20);
        rd(1'b0, v); chk("R9 ns eoi", v, 8'h90);
        wr(1'b0, 8'h67);
        rd(1'b0, v); chk("R10 spec eoi", v, 8'h10);
        wr(1'b0, 8'hE4);
        rd(1'b0, v); chk("R10 spec rot eoi", v, 8'h00);
        irr_in = 8'h28; poll(v); chk("R10 offset 5", v, 8'h85);
        wr(1'b0, 8'h40);
        rd(1'b0, v); chk("R8 code 2 nop", v, 8'h20);
        wr(1'b0, 8'h20);
        wr(1'b0, 8'h20);
        rd(1'b0, v); chk("R9 ns eoi empty", v, 8'h00);
        wr(1'b0, 8'hC2);
        poll(v); chk("R10 set priority", v, 8'h83);
        #1; chk("R11 equal rank", {7'b0, int_out}, 8'h00);
        wr(1'b0, 8'hA0);
        poll(v); chk("R9 R10 ns rot", v, 8'h85);
        irr_in = 8'h00;
    endtask

    task automatic t_smm();
        logic [7:0] v;
        init_single();
        wr(1'b0, 8'h0B);
        irr_in = 8'h08; poll(v); chk("R12 line3", v, 8'h83);
        irr_in = 8'h01; poll(v); chk("R12 line0", v, 8'h80);
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h68);
        irr_in = 8'h00;
        wr(1'b0, 8'h20);
        rd(1'b0, v); chk("R9 smm ns eoi", v, 8'h01);
        irr_in = 8'h04; #1;
        chk("R11 smm on", {7'b0, int_out}, 8'h01);
        wr(1'b0, 8'h48);
        chk("R7 R11 smm off", {7'b0, int_out}, 8'h00);
        irr_in = 8'h00;
    endtask

    task automatic t_aeoi();
        logic [7:0] v;
        lvl_mask = 8'h00;
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h02);
        wr(1'b0, 8'h80);
        wr(1'b0, 8'h0B);
        irr_in = 8'h04; poll(v); chk("R12 aeoi poll", v, 8'h82);
        chk("R12 edge clear", irr_clr, 8'h04);
        rd(1'b0, v); chk("R5 R12 aeoi isr", v, 8'h00);
        irr_in = 8'h0A; poll(v); chk("R8 R12 rotated", v, 8'h83);
        wr(1'b0, 8'h00);
        lvl_mask = 8'h02;
        poll(v); chk("R8 rot off", v, 8'h81);
        chk("R12 level kept", irr_clr, 8'h00);
        poll(v); chk("R8 offset held", v, 8'h81);
        irr_in = 8'h00; lvl_mask = 8'h00;
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_init_full();
        t_init_skip3();
        t_init_single();
        t_mode_read();
        t_eoi();
        t_smm();
        t_aeoi();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule